// File: doc/BRIEF.md
# Converter Power-State and Wake-Up Controller

This block sequences the power state of a sampled data converter. It chooses between full operation, a nap state and a sleep state. In nap, the conversion core is off and the reference stays powered. In sleep, both are off. The request comes from one of two places, picked by a mode pin. In serial mode it comes from a two-bit power field and a separate output-disable bit. In parallel mode it comes from three strap pins. Those same pins also set the clock duty-cycle stabilizer and the output drive current.

When a low-power state ends, the block passes through a wake phase. A down-counter runs during this phase and the data-valid flag stays low. The wake time depends on what the reference has been through. A nap with the sample clock running throughout needs `NAP_CYC` cycles. A sleep, a nap entered from a sleep, or a nap during which the clock-present indication dropped needs `T_REF_CYC + 2500` cycles. The output-disable control lowers the enables of the data, overflow and clock-out drivers together. All timing is counted in sample-clock cycles.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: During reset and after it, with no edge since, core power, reference power and data-valid are all 0. The block then behaves as if it were sleeping, so its first wake-up takes the long delay.
- R2: The power request is decoded as follows. In serial mode (`par_mode`=0), `reg_pwr` = 00 means run, 01 means nap, and 10 or 11 means sleep. In parallel mode (`par_mode`=1), `pin_sleep`=1 means sleep and 0 means run.
- R3: After any clock edge that samples a nap request, core power is 0 and reference power is 1.
- R4: After any clock edge that samples a sleep request, core power and reference power are both 0. After any edge that samples a run request, both are 1.
- R5: Take a nap in which `clk_present` was 1 on every edge. A run request then makes data-valid rise on exactly the (`NAP_CYC`+1)-th edge, counting the first edge that samples the request.
- R6: Take a nap in which any edge sampled `clk_present`=0, including the edge that samples the run request. That wake-up takes the long delay: data-valid rises on edge `T_REF_CYC`+2501.
- R7: A wake from sleep takes the long delay. So does a wake from a nap that was entered from sleep, or from a long wake-up that was cut short, before data-valid was ever reached.
- R8: A nap or sleep request sampled during a wake-up ends the wake-up on that edge. Data-valid stays 0. A later run request reloads the full delay.
- R9: In serial mode, `reg_oe_dis`=1 drives `data_oe`, `ovf_oe` and `clkout_oe` all to 0, combinationally. Otherwise all three are 1. The three are always equal.
- R10: In parallel mode, `dcs_en` follows `pin_dcs` (1 = stabilizer on) and `lvds_half_cur` follows `pin_lvds` (0 = 3.5 mA, 1 = 1.75 mA). In serial mode both outputs are 0 and the pins have no effect.
- R11: In parallel mode, `reg_pwr` and `reg_oe_dis` have no effect, so a nap cannot be requested.
- R12: Data-valid is never 1 while core or reference power is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | 1 = strap-pin configuration, 0 = register configuration |
| pin_dcs | input | 1 | Parallel mode: duty-cycle stabilizer on |
| pin_sleep | input | 1 | Parallel mode: sleep request |
| pin_lvds | input | 1 | Parallel mode: reduced output current |
| reg_pwr | input | 2 | Serial power field: 00 run, 01 nap, 1x sleep |
| reg_oe_dis | input | 1 | Serial output-disable bit |
| clk_present | input | 1 | Sample clock is running |
| core_pwr_en | output | 1 | Conversion core power enable |
| ref_pwr_en | output | 1 | Reference power enable |
| data_valid | output | 1 | Conversion data is valid |
| data_oe | output | 1 | Data pin driver enable |
| ovf_oe | output | 1 | Overflow pin driver enable |
| clkout_oe | output | 1 | Clock-out pin driver enable |
| dcs_en | output | 1 | Duty-cycle stabilizer enable |
| lvds_half_cur | output | 1 | Output current select: 1 = 1.75 mA |

## Verification
Two events can fall on the same edge. One is the last count of a nap wake-up. The other is the first sample of `clk_present`=0, or of a new power-down request. The bench places a clock drop on the very edge that samples the run request, and it interrupts wake-ups part-way. It then measures in edges when data-valid rises, and compares that against the short or long delay that the requirements predict. Random request mixes check the power enables edge by edge. They also check the combinational pin mapping in both configuration modes.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_NAP   = 2'd1,
    PS_SLEEP = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    RQ_RUN   = 2'd0,
    RQ_NAP   = 2'd1,
    RQ_SLEEP = 2'd2
  } pwr_req_e;
endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
  import pwr_wake_pkg::*;
(
  input  logic       par_mode,
  input  logic       pin_dcs,
  input  logic       pin_sleep,
  input  logic       pin_lvds,
  input  logic [1:0] reg_pwr,
  input  logic       reg_oe_dis,
  output pwr_req_e   req,
  output logic       drv_en,
  output logic       dcs_en,
  output logic       lvds_half
);
  always_comb begin
    if (par_mode) begin
      req       = pin_sleep ? RQ_SLEEP : RQ_RUN;
      drv_en    = 1'b1;
      dcs_en    = pin_dcs;
      lvds_half = pin_lvds;
    end else begin
      if (reg_pwr[1])      req = RQ_SLEEP;
      else if (reg_pwr[0]) req = RQ_NAP;
      else                 req = RQ_RUN;
      drv_en    = ~reg_oe_dis;
      dcs_en    = 1'b0;
      lvds_half = 1'b0;
    end
  end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_wake_pkg::*;
#(
  parameter int NAP_CYC   = 100,
  parameter int SLEEP_CYC = 3000,
  parameter int CW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pwr_req_e      req,
  input  logic          clk_present,
  input  logic          tmr_last,
  output pwr_state_e    state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);
  pwr_state_e state_n;
  logic       slow_q;

  always_comb begin
    state_n  = state;
    tmr_load = 1'b0;
    tmr_val  = CW'(SLEEP_CYC);
    case (state)
      PS_RUN: begin
        if (req == RQ_NAP)        state_n = PS_NAP;
        else if (req == RQ_SLEEP) state_n = PS_SLEEP;
      end
      PS_NAP: begin
        if (req == RQ_SLEEP) state_n = PS_SLEEP;
        else if (req == RQ_RUN) begin
          state_n  = PS_WAKE;
          tmr_load = 1'b1;
          tmr_val  = (slow_q || !clk_present) ? CW'(SLEEP_CYC) : CW'(NAP_CYC);
        end
      end
      PS_SLEEP: begin
        if (req == RQ_NAP) state_n = PS_NAP;
        else if (req == RQ_RUN) begin
          state_n  = PS_WAKE;
          tmr_load = 1'b1;
        end
      end
      default: begin
        if (req == RQ_NAP)        state_n = PS_NAP;
        else if (req == RQ_SLEEP) state_n = PS_SLEEP;
        else if (tmr_last)        state_n = PS_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PS_SLEEP;
      slow_q <= 1'b1;
    end else begin
      state <= state_n;
      if (state_n == PS_SLEEP)                  slow_q <= 1'b1;
      else if (state == PS_NAP && !clk_present) slow_q <= 1'b1;
      else if (state_n == PS_RUN)               slow_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int NAP_CYC   = 100,
  parameter int T_REF_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode,
  input  logic       pin_dcs,
  input  logic       pin_sleep,
  input  logic       pin_lvds,
  input  logic [1:0] reg_pwr,
  input  logic       reg_oe_dis,
  input  logic       clk_present,
  output logic       core_pwr_en,
  output logic       ref_pwr_en,
  output logic       data_valid,
  output logic       data_oe,
  output logic       ovf_oe,
  output logic       clkout_oe,
  output logic       dcs_en,
  output logic       lvds_half_cur
);
  localparam int SLEEP_CYC = T_REF_CYC + 2500;
  localparam int MAX_CYC   = (SLEEP_CYC > NAP_CYC) ? SLEEP_CYC : NAP_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  pwr_req_e      req;
  pwr_state_e    state;
  logic          drv_en;
  logic          tmr_load;
  logic          tmr_last;
  logic [CW-1:0] tmr_val;

  pwr_req_decode u_dec (
    .par_mode   (par_mode),
    .pin_dcs    (pin_dcs),
    .pin_sleep  (pin_sleep),
    .pin_lvds   (pin_lvds),
    .reg_pwr    (reg_pwr),
    .reg_oe_dis (reg_oe_dis),
    .req        (req),
    .drv_en     (drv_en),
    .dcs_en     (dcs_en),
    .lvds_half  (lvds_half_cur)
  );

  pwr_state_fsm #(.NAP_CYC(NAP_CYC), .SLEEP_CYC(SLEEP_CYC), .CW(CW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .clk_present (clk_present),
    .tmr_last    (tmr_last),
    .state       (state),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  pwr_wake_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (state == PS_WAKE),
    .last     (tmr_last)
  );

  assign core_pwr_en = (state == PS_RUN) || (state == PS_WAKE);
  assign ref_pwr_en  = (state != PS_SLEEP);
  assign data_valid  = (state == PS_RUN);
  assign data_oe     = drv_en;
  assign ovf_oe      = drv_en;
  assign clkout_oe   = drv_en;
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
  parameter int NAP_CYC = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       par_mode,
  input logic       pin_sleep,
  input logic [1:0] reg_pwr,
  input logic       reg_oe_dis,
  input logic       core_pwr_en,
  input logic       ref_pwr_en,
  input logic       data_valid,
  input logic       data_oe,
  input logic       ovf_oe,
  input logic       clkout_oe
);
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                          low_run <= 0;
    else if (core_pwr_en && !data_valid) low_run <= low_run + 1;
    else                                 low_run <= 0;
  end

  p_valid_needs_power_r12: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (core_pwr_en && ref_pwr_en));

  p_core_needs_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_pwr_en |-> !core_pwr_en);

  p_nap_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && reg_pwr == 2'b01) |=> (!core_pwr_en && ref_pwr_en && !data_valid));

  p_sleep_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && pin_sleep) |=> (!core_pwr_en && !ref_pwr_en));

  p_min_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> (low_run >= NAP_CYC));

  p_oe_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe == ovf_oe) && (ovf_oe == clkout_oe));

  p_oe_par_r11: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> data_oe);

  p_oe_dis_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && reg_oe_dis) |-> !data_oe);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.NAP_CYC(NAP_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .par_mode    (par_mode),
  .pin_sleep   (pin_sleep),
  .reg_pwr     (reg_pwr),
  .reg_oe_dis  (reg_oe_dis),
  .core_pwr_en (core_pwr_en),
  .ref_pwr_en  (ref_pwr_en),
  .data_valid  (data_valid),
  .data_oe     (data_oe),
  .ovf_oe      (ovf_oe),
  .clkout_oe   (clkout_oe)
);

// File: tb/pwr_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb;
  localparam int NAP  = 100;
  localparam int TREF = 200;
  localparam int SLP  = TREF + 2500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_mode = 1'b0, pin_dcs = 1'b0, pin_sleep = 1'b0, pin_lvds = 1'b0;
  logic [1:0] reg_pwr = 2'b00;
  logic reg_oe_dis = 1'b0, clk_present = 1'b1;
  logic core_pwr_en, ref_pwr_en, data_valid, data_oe, ovf_oe, clkout_oe, dcs_en, lvds_half_cur;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl #(.NAP_CYC(NAP), .T_REF_CYC(TREF)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .pin_dcs(pin_dcs),
    .pin_sleep(pin_sleep), .pin_lvds(pin_lvds), .reg_pwr(reg_pwr),
    .reg_oe_dis(reg_oe_dis), .clk_present(clk_present),
    .core_pwr_en(core_pwr_en), .ref_pwr_en(ref_pwr_en), .data_valid(data_valid),
    .data_oe(data_oe), .ovf_oe(ovf_oe), .clkout_oe(clkout_oe),
    .dcs_en(dcs_en), .lvds_half_cur(lvds_half_cur)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // edges from the first sample of the current request until data-valid is seen
  task automatic edges_to_valid(output int n);
    n = 0;
    while (n < 5000) begin
      step();
      n++;
      if (data_valid) break;
    end
  endtask

  // expected power pair from a sampled request: {core, ref}
  function automatic logic [1:0] exp_pwr(input logic pm, input logic ps, input logic [1:0] rp);
    if (pm) return ps ? 2'b00 : 2'b11;
    if (rp[1]) return 2'b00;
    if (rp[0]) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic exp_oe(input logic pm, input logic dis);
    return pm ? 1'b1 : ~dis;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [1:0] pw;
    void'($urandom(32'h5eed_1234));
    step(3);
    // R1 reset state
    check("R1 core", core_pwr_en, 0);
    check("R1 ref", ref_pwr_en, 0);
    check("R1 valid", data_valid, 0);
    check("R9 oe at reset", data_oe, 1);
    rst_n = 1'b1;
    // R1/R7 first wake-up is long
    edges_to_valid(n);
    check("R1 first wake edges", n, SLP + 1);
    // R3 nap
    reg_pwr = 2'b01;
    step();
    check("R3 core", core_pwr_en, 0);
    check("R3 ref", ref_pwr_en, 1);
    step(10);
    reg_pwr = 2'b00;
    edges_to_valid(n);
    check("R5 nap wake edges", n, NAP + 1);
    // R6 clock drop during nap
    reg_pwr = 2'b01;
    step(4);
    clk_present = 1'b0;
    step(3);
    clk_present = 1'b1;
    step(3);
    reg_pwr = 2'b00;
    edges_to_valid(n);
    check("R6 clock-lost wake edges", n, SLP + 1);
    // R6 clock drop on the very edge sampling run
    reg_pwr = 2'b01;
    step(5);
    reg_pwr = 2'b00;
    clk_present = 1'b0;
    step();
    clk_present = 1'b1;
    n = 1;
    while (!data_valid && n < 5000) begin step(); n++; end
    check("R6 coincident drop edges", n, SLP + 1);
    // R7 sleep then nap then run
    reg_pwr = 2'b10;
    step(3);
    check("R4 sleep core", core_pwr_en, 0);
    check("R4 sleep ref", ref_pwr_en, 0);
    reg_pwr = 2'b01;
    step(5);
    reg_pwr = 2'b00;
    edges_to_valid(n);
    check("R7 sleep-nap wake edges", n, SLP + 1);
    // R8 abort of a nap wake-up
    reg_pwr = 2'b01;
    step(5);
    reg_pwr = 2'b00;
    step(50);
    check("R8 valid during wake", data_valid, 0);
    reg_pwr = 2'b01;
    step();
    check("R8 abort core", core_pwr_en, 0);
    check("R8 abort valid", data_valid, 0);
    reg_pwr = 2'b00;
    edges_to_valid(n);
    check("R8 reloaded nap edges", n, NAP + 1);
    // R7 aborted long wake-up then nap keeps long delay
    reg_pwr = 2'b11;
    step(3);
    reg_pwr = 2'b00;
    step(300);
    reg_pwr = 2'b01;
    step(5);
    reg_pwr = 2'b00;
    edges_to_valid(n);
    check("R7 aborted-long wake edges", n, SLP + 1);
    // R9 output disable
    reg_oe_dis = 1'b1;
    #1;
    check("R9 data_oe", data_oe, 0);
    check("R9 ovf_oe", ovf_oe, 0);
    check("R9 clkout_oe", clkout_oe, 0);
    // R11 parallel ignores registers
    par_mode = 1'b1;
    reg_pwr = 2'b01;
    #1;
    check("R11 oe in parallel", data_oe, 1);
    step(3);
    check("R11 nap ignored core", core_pwr_en, 1);
    check("R11 valid kept", data_valid, 1);
    // R10 pin mapping
    pin_dcs = 1'b1; pin_lvds = 1'b0;
    #1;
    check("R10 dcs", dcs_en, 1);
    check("R10 lvds", lvds_half_cur, 0);
    par_mode = 1'b0;
    #1;
    check("R10 serial dcs", dcs_en, 0);
    // random mix
    for (int it = 0; it < 3000; it++) begin
      par_mode   = $urandom_range(0, 1);
      pin_dcs    = $urandom_range(0, 1);
      pin_sleep  = $urandom_range(0, 1);
      pin_lvds   = $urandom_range(0, 1);
      reg_pwr    = 2'($urandom_range(0, 3));
      reg_oe_dis = $urandom_range(0, 1);
      clk_present = ($urandom_range(0, 7) != 0);
      #1;
      check("R9 rand oe", data_oe, exp_oe(par_mode, reg_oe_dis));
      check("R10 rand dcs", dcs_en, par_mode & pin_dcs);
      check("R10 rand lvds", lvds_half_cur, par_mode & pin_lvds);
      pw = exp_pwr(par_mode, pin_sleep, reg_pwr);
      step();
      check("R2 rand core", core_pwr_en, pw[1]);
      check("R2 rand ref", ref_pwr_en, pw[0]);
      if (data_valid) check("R12 rand valid power", core_pwr_en & ref_pwr_en, 1);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule